// File: doc/BRIEF.md
# Serial NOR Flash Target Emulator

This block behaves as the target side of a small serial NOR flash on a four-wire serial bus in clock mode 0. The bus clock, the active-low select and the master-out line are brought into the system clock domain, so the system clock has to run several times faster than the bus clock. Data is taken on rising bus-clock edges, and the return line changes after falling edges, most significant bit first. Every frame begins with a one-byte opcode. Writes, status updates and erases take effect when the select line rises at the end of the frame. Read data and status are returned within the frame.

The storage is a parameterised byte array split into sectors and pages. A status byte reports a busy flag, a write-enable latch and two protection bits. After each erase or programmed byte, busy stays set for a programmable number of cycles, so the master has to poll the status between bytes. Byte programming uses an auto-increment mode. The first frame carries an address and one data byte. Each later frame carries one data byte, which goes to the next address. After reset the array is wiped to 0xFF in the background, and busy is set while that runs.

Top module: `spi_flash_emu`

## Requirements
- R1: After reset the status reads busy (bit 0 = 1) while the array is wiped. Once busy clears, status reads 0x00 and every byte reads 0xFF.
- R2: Opcode 0x05 returns the status byte on every byte clocked after the opcode, and it is accepted even while busy. The status bits are: bit 0 busy, bit 1 write-enable latch, bits 3:2 protection, bits 7:4 zero. The return line is high outside a frame and during the opcode byte.
- R3: Opcode 0x90 followed by three address bytes returns the device ID high byte first (default 0xBF43). Further bytes keep alternating high, low.
- R4: Opcode 0x06 sets status bit 1, and opcode 0x04 clears it.
- R5: A frame of 0x01 followed by a data byte changes the protection bits only when the frame just before it was a single 0x50. Only data bits 3:2 are stored, in status bits 3:2. Without that, the frame has no effect.
- R6: Erase and program frames have no effect unless status bit 1 is set and status bits 3:2 are both zero.
- R7: The first 0xAF frame carries a 24-bit address and a data byte. While the mode lasts, a 0xAF frame with one data byte programs the next sequential address. Opcode 0x04 ends the mode, after which a two-byte 0xAF frame is ignored.
- R8: Programming can only clear bits: the stored byte becomes the old byte AND the new data.
- R9: Opcode 0x20 with a 24-bit address sets every byte of the 4096-byte sector that holds the address to 0xFF and leaves the other sectors untouched.
- R10: Busy is set from the end of a program or erase frame for at least BUSY_CYCLES cycles. While busy, every opcode except 0x05 is ignored; for example, 0x04 leaves the latch set.
- R11: Opcode 0x03 with a 24-bit address returns bytes from that address and increments while select stays low. The address wraps modulo the array size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiClk | input | 1 | Bus clock from the master, idle low |
| spiCsN | input | 1 | Active-low frame select |
| spiMosi | input | 1 | Serial data from the master |
| spiMiso | output | 1 | Serial data to the master |

## Verification
The assertions check the gating rules on every cycle: a program strobe never fires without the write latch and with protection set, never while the wipe walker runs, and is always followed by busy. They also check that the protection bits move only at the end of a frame that follows an enable frame, that the walker stops at the end of its range, and that the return line idles high. The bench scenarios are the only way to show the data results: the AND of programmed bytes, the sector boundaries of an erase, address wrap on streaming reads, the alternating ID bytes, and the ignored commands while busy or after auto-increment mode ends. They compare these against a reference byte array that the bench keeps.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;
  localparam int ADDR_W = 24;

  localparam logic [7:0] CMD_SETSTAT  = 8'h01;
  localparam logic [7:0] CMD_READ     = 8'h03;
  localparam logic [7:0] CMD_WRLOCK   = 8'h04;
  localparam logic [7:0] CMD_GETSTAT  = 8'h05;
  localparam logic [7:0] CMD_WRUNLOCK = 8'h06;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_STATARM  = 8'h50;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_AUTOPROG = 8'hAF;

  // strobes from control to the storage datapath
  typedef struct packed {
    logic              progEn;
    logic [ADDR_W-1:0] progAddr;
    logic [7:0]        progData;
    logic              eraseGo;
    logic [ADDR_W-1:0] eraseAddr;
    logic [ADDR_W-1:0] rdAddr;
  } memStrobe_t;
endpackage

// File: rtl/flash_mem.sv
module flash_mem
  import flash_emu_pkg::*;
#(
  parameter int MEM_BYTES    = 8192,
  parameter int SECTOR_BYTES = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  memStrobe_t strobe,
  output logic [7:0] rdData,
  output logic       walkBusy
);
  localparam int MAW = $clog2(MEM_BYTES);
  localparam logic [MAW-1:0] SECT_MASK = MAW'(SECTOR_BYTES - 1);
  localparam logic [MAW-1:0] LAST_IDX  = MAW'(MEM_BYTES - 1);

  logic [7:0]     cells [MEM_BYTES];
  logic           wRun;
  logic [MAW-1:0] wIdx;
  logic [MAW-1:0] wEnd;
  logic [MAW-1:0] progIdx;
  logic [MAW-1:0] eraseIdx;

  assign progIdx  = strobe.progAddr[MAW-1:0];
  assign eraseIdx = strobe.eraseAddr[MAW-1:0];

  // storage: walker fills 0xFF, programming can only clear bits
  always_ff @(posedge clk) begin
    if (wRun) cells[wIdx] <= 8'hFF;
    else if (strobe.progEn) cells[progIdx] <= cells[progIdx] & strobe.progData;
  end

  // background fill walker: whole array after reset, one sector per erase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wRun <= 1'b1;
      wIdx <= '0;
      wEnd <= LAST_IDX;
    end else if (wRun) begin
      if (wIdx == wEnd) wRun <= 1'b0;
      else wIdx <= wIdx + 1'b1;
    end else if (strobe.eraseGo) begin
      wRun <= 1'b1;
      wIdx <= eraseIdx & ~SECT_MASK;
      wEnd <= eraseIdx | SECT_MASK;
    end
  end

  assign rdData   = cells[strobe.rdAddr[MAW-1:0]];
  assign walkBusy = wRun;

  // R10
  prog_not_walking_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.progEn |-> !wRun);
  // R9
  walk_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wRun && wIdx == wEnd) |=> !wRun);
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_emu_pkg::*;
#(
  parameter logic [15:0] DEVICE_ID   = 16'hBF43,
  parameter int          BUSY_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       mosi,
  output logic       miso,
  input  logic       walkBusy,
  input  logic [7:0] rdData,
  output memStrobe_t strobe
);
  localparam int BCW = $clog2(BUSY_CYCLES + 1);

  logic [2:0]        sclkSync, csSync;
  logic [1:0]        mosiSync;
  logic              sclkRise, sclkFall, csActive, frameEnd;
  logic [2:0]        bitCnt, byteIdx;
  logic [6:0]        rxShift;
  logic [7:0]        rxByte, curOp, opcode, dataB1, dataB4, txShift, txNext, statusByte;
  logic [ADDR_W-1:0] addrReg, fullAddr, readPtr, aaiPtr, rdAddrMux;
  logic              wel, ewsrArm, aaiOn, idPhase, busy, writable, accept;
  logic [1:0]        prot;
  logic [BCW-1:0]    busyCnt;

  assign sclkRise   = sclkSync[1] & ~sclkSync[2];
  assign sclkFall   = ~sclkSync[1] & sclkSync[2];
  assign csActive   = ~csSync[1];
  assign frameEnd   = csSync[1] & ~csSync[2];
  assign rxByte     = {rxShift, mosiSync[1]};
  assign curOp      = (byteIdx == 3'd0) ? rxByte : opcode;
  assign fullAddr   = {addrReg[15:0], rxByte};
  assign busy       = (busyCnt != '0) | walkBusy;
  assign statusByte = {4'b0000, prot, wel, busy};
  assign writable   = wel & (prot == 2'b00);
  assign accept     = (byteIdx != 3'd0) && (!busy || opcode == CMD_GETSTAT);
  assign rdAddrMux  = (byteIdx == 3'd3) ? fullAddr : readPtr;
  assign miso       = txShift[7];

  // next byte to return
  always_comb begin
    txNext = 8'hFF;
    if (!busy || curOp == CMD_GETSTAT) begin
      case (curOp)
        CMD_GETSTAT: txNext = statusByte;
        CMD_READ:    if (byteIdx >= 3'd3) txNext = rdData;
        CMD_IDENT:   if (byteIdx >= 3'd3)
                       txNext = (byteIdx == 3'd3 || !idPhase) ? DEVICE_ID[15:8] : DEVICE_ID[7:0];
        default:     txNext = 8'hFF;
      endcase
    end
  end

  // strobes to the datapath
  always_comb begin
    strobe.progEn    = frameEnd && accept && opcode == CMD_AUTOPROG && writable &&
                       ((aaiOn && byteIdx >= 3'd2) || (!aaiOn && byteIdx >= 3'd5));
    strobe.progAddr  = aaiOn ? aaiPtr : addrReg;
    strobe.progData  = aaiOn ? dataB1 : dataB4;
    strobe.eraseGo   = frameEnd && accept && opcode == CMD_ERASE && writable && byteIdx >= 3'd4;
    strobe.eraseAddr = addrReg;
    strobe.rdAddr    = rdAddrMux;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
      bitCnt   <= '0;
      byteIdx  <= '0;
      rxShift  <= '0;
      opcode   <= '0;
      addrReg  <= '0;
      dataB1   <= '0;
      dataB4   <= '0;
      readPtr  <= '0;
      idPhase  <= 1'b0;
      txShift  <= 8'hFF;
      wel      <= 1'b0;
      prot     <= 2'b00;
      ewsrArm  <= 1'b0;
      aaiOn    <= 1'b0;
      aaiPtr   <= '0;
      busyCnt  <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], sclk};
      csSync   <= {csSync[1:0], csN};
      mosiSync <= {mosiSync[0], mosi};

      // serial shifter
      if (!csActive) begin
        bitCnt  <= '0;
        byteIdx <= '0;
        txShift <= 8'hFF;
      end else if (sclkRise) begin
        bitCnt  <= bitCnt + 1'b1;
        rxShift <= rxByte[6:0];
        if (bitCnt == 3'd7) begin
          txShift <= txNext;
          if (byteIdx != 3'd7) byteIdx <= byteIdx + 1'b1;
          if (byteIdx == 3'd0) opcode <= rxByte;
          if (byteIdx >= 3'd1 && byteIdx <= 3'd3) addrReg <= fullAddr;
          if (byteIdx == 3'd1) dataB1 <= rxByte;
          if (byteIdx == 3'd4) dataB4 <= rxByte;
          if (byteIdx >= 3'd3) begin
            readPtr <= rdAddrMux + 1'b1;
            idPhase <= (byteIdx == 3'd3) ? 1'b1 : ~idPhase;
          end
        end
      end else if (sclkFall && bitCnt != 3'd0) begin
        txShift <= {txShift[6:0], 1'b1};
      end

      // frame-end commit
      if (frameEnd) begin
        ewsrArm <= accept && opcode == CMD_STATARM && byteIdx == 3'd1;
        if (accept) begin
          case (opcode)
            CMD_WRUNLOCK: wel <= 1'b1;
            CMD_WRLOCK: begin
              wel   <= 1'b0;
              aaiOn <= 1'b0;
            end
            CMD_SETSTAT: if (ewsrArm && byteIdx >= 3'd2) prot <= dataB1[3:2];
            default: ;
          endcase
        end
      end
      if (strobe.progEn) begin
        aaiOn  <= 1'b1;
        aaiPtr <= strobe.progAddr + 1'b1;
      end

      // busy hold
      if (strobe.progEn || strobe.eraseGo) busyCnt <= BCW'(BUSY_CYCLES);
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end

  // R6
  prog_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.progEn || strobe.eraseGo) |-> (wel && prot == 2'b00));
  // R10
  busy_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.progEn || strobe.eraseGo) |=> busy);
  // R5
  prot_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(frameEnd && ewsrArm) |=> $stable(prot));
  // R2
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> miso);
endmodule

// File: rtl/spi_flash_emu.sv
module spi_flash_emu
  import flash_emu_pkg::*;
#(
  parameter int          MEM_BYTES    = 8192,
  parameter int          SECTOR_BYTES = 4096,
  parameter int          BUSY_CYCLES  = 40,
  parameter logic [15:0] DEVICE_ID    = 16'hBF43
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiClk,
  input  logic spiCsN,
  input  logic spiMosi,
  output logic spiMiso
);
  memStrobe_t memStrobe;
  logic [7:0] memRdData;
  logic       memWalkBusy;

  flash_ctrl #(
    .DEVICE_ID  (DEVICE_ID),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclk    (spiClk),
    .csN     (spiCsN),
    .mosi    (spiMosi),
    .miso    (spiMiso),
    .walkBusy(memWalkBusy),
    .rdData  (memRdData),
    .strobe  (memStrobe)
  );

  flash_mem #(
    .MEM_BYTES   (MEM_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES)
  ) i_mem (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (memStrobe),
    .rdData  (memRdData),
    .walkBusy(memWalkBusy)
  );
endmodule

// File: tb/test_spi_flash_emu.sv
module test_spi_flash_emu;
  localparam int MEMB = 8192;
  localparam int SECT = 4096;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN, spiClk, spiCsN, spiMosi, spiMiso;
  int   checks = 0, failures = 0;
  bit   finished = 1'b0;
  logic [7:0] model [MEMB];

  always #2.5 clk = ~clk;

  spi_flash_emu #(.MEM_BYTES(MEMB), .SECTOR_BYTES(SECT), .BUSY_CYCLES(600),
                  .DEVICE_ID(16'hBF43)) i_spi_flash_emu (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spiMosi = tx[i];
      repeat (HALF) @(negedge clk);
      spiClk = 1'b1;
      rx[i] = spiMiso;
      repeat (HALF) @(negedge clk);
      spiClk = 1'b0;
    end
  endtask

  task automatic csLow();
    spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    csLow(); xfer(op, d); csHigh();
  endtask

  task automatic sendHdr(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] d;
    xfer(op, d); xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d);
  endtask

  task automatic getStatus(output logic [7:0] st);
    logic [7:0] d;
    csLow(); xfer(8'h05, d); xfer(8'hFF, st); csHigh();
  endtask

  task automatic waitReady();
    logic [7:0] st;
    for (int k = 0; k < 200; k++) begin
      getStatus(st);
      if (!st[0]) return;
    end
    chk("ready poll", 32'(st[0]), 32'd0);
  endtask

  task automatic setStat(input logic [7:0] v);
    logic [7:0] d;
    csLow(); xfer(8'h01, d); xfer(v, d); csHigh();
  endtask

  task automatic progFirst(input logic [23:0] a, input logic [7:0] v);
    logic [7:0] d;
    csLow(); sendHdr(8'hAF, a); xfer(v, d); csHigh();
  endtask

  task automatic progNext(input logic [7:0] v);
    logic [7:0] d;
    csLow(); xfer(8'hAF, d); xfer(v, d); csHigh();
  endtask

  task automatic readCheck(input logic [23:0] a, input int n, input string tag);
    logic [7:0] d;
    csLow(); sendHdr(8'h03, a);
    for (int i = 0; i < n; i++) begin
      xfer(8'hFF, d);
      chk(tag, 32'(d), 32'(model[(int'(a) + i) % MEMB]));
    end
    csHigh();
  endtask

  initial begin
    logic [7:0] st, d, v;
    logic [23:0] a, base;
    int seedDummy;
    seedDummy = $urandom(32'd1234);
    for (int i = 0; i < MEMB; i++) model[i] = 8'hFF;
    rstN = 1'b0; spiClk = 1'b0; spiCsN = 1'b1; spiMosi = 1'b0;
    repeat (10) @(negedge clk);
    chk("R2 idle miso in reset", 32'(spiMiso), 32'd1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: busy during wipe, then clear
    getStatus(st);
    chk("R1 busy after reset", 32'(st), 32'h01);
    waitReady();
    getStatus(st);
    chk("R1 status after wipe", 32'(st), 32'h00);
    readCheck(24'h001FF0, 4, "R1 wiped contents");

    // R3: identification
    csLow(); sendHdr(8'h90, 24'h0);
    xfer(8'hFF, d); chk("R3 id high", 32'(d), 32'hBF);
    xfer(8'hFF, d); chk("R3 id low", 32'(d), 32'h43);
    xfer(8'hFF, d); chk("R3 id alternates", 32'(d), 32'hBF);
    csHigh();

    // R4 / R2: latch and repeated status bytes
    cmd1(8'h06);
    csLow(); xfer(8'h05, d);
    chk("R2 miso high in opcode byte", 32'(d), 32'hFF);
    for (int i = 0; i < 3; i++) begin
      xfer(8'hFF, d); chk("R2 R4 repeated status", 32'(d), 32'h02);
    end
    csHigh();
    cmd1(8'h04);
    getStatus(st); chk("R4 latch cleared", 32'(st), 32'h00);

    // R6: program without latch ignored
    progFirst(24'h000010, 8'h12);
    getStatus(st); chk("R6 no busy without latch", 32'(st), 32'h00);
    readCheck(24'h000010, 1, "R6 unlatched program ignored");

    // R5: status write gating
    setStat(8'h0C);
    getStatus(st); chk("R5 ungated write ignored", 32'(st), 32'h00);
    cmd1(8'h50); getStatus(st); setStat(8'h0C);
    getStatus(st); chk("R5 non-adjacent arm ignored", 32'(st), 32'h00);
    cmd1(8'h50); setStat(8'hFF);
    getStatus(st); chk("R5 only bits 3:2 stored", 32'(st), 32'h0C);

    // R6: protected program ignored
    cmd1(8'h06);
    progFirst(24'h000020, 8'h00);
    getStatus(st); chk("R6 protected no busy", 32'(st), 32'h0E);
    readCheck(24'h000020, 1, "R6 protected program ignored");
    cmd1(8'h50); setStat(8'h00);
    getStatus(st); chk("R5 protection cleared", 32'(st), 32'h02);

    // R7 / R10: auto-increment programming
    progFirst(24'h000100, 8'hA5); model[16'h100] = 8'hA5;
    getStatus(st); chk("R10 busy after program", 32'(st), 32'h03);
    cmd1(8'h04);
    waitReady();
    getStatus(st); chk("R10 disable ignored while busy", 32'(st), 32'h02);
    for (int i = 1; i < 6; i++) begin
      v = 8'(i * 37 + 5);
      progNext(v); model[16'h100 + i] = v;
      waitReady();
    end
    readCheck(24'h000100, 7, "R7 R11 sequential programming");
    cmd1(8'h04);
    getStatus(st); chk("R7 disable ends mode", 32'(st), 32'h00);
    cmd1(8'h06);
    progNext(8'h00);
    getStatus(st); chk("R7 short frame after end no busy", 32'(st), 32'h02);
    readCheck(24'h000106, 1, "R7 short frame ignored");

    // R8: AND on reprogram
    progFirst(24'h000100, 8'h0F); model[16'h100] = 8'h05;
    waitReady(); cmd1(8'h04);
    readCheck(24'h000100, 1, "R8 program ANDs");

    // sector-1 marker for the erase check
    cmd1(8'h06); progFirst(24'h001005, 8'h5A); model[16'h1005] = 8'h5A;
    waitReady(); cmd1(8'h04);

    // random programs (R8) with readback
    for (int n = 0; n < 16; n++) begin
      a = 24'($urandom % MEMB);
      v = 8'($urandom);
      cmd1(8'h06); progFirst(a, v);
      model[a[12:0]] = model[a[12:0]] & v;
      waitReady(); cmd1(8'h04);
      readCheck(a, 2, "R8 random program");
    end

    // R6: erase without latch ignored
    csLow(); sendHdr(8'h20, 24'h000100); csHigh();
    readCheck(24'h000100, 1, "R6 unlatched erase ignored");

    // R9: sector erase
    cmd1(8'h06);
    csLow(); sendHdr(8'h20, 24'h000123); csHigh();
    getStatus(st); chk("R9 R10 busy during erase", 32'(st[0]), 32'd1);
    waitReady(); cmd1(8'h04);
    base = 24'h0;
    for (int i = 0; i < SECT; i++) model[i] = 8'hFF;
    readCheck(24'h000100, 7, "R9 erased sector");
    readCheck(24'h000FFE, 2, "R9 erased sector end");
    readCheck(24'h001005, 1, "R9 neighbour intact");

    // R11: wrap around the top
    readCheck(24'(MEMB - 2), 4, "R11 read wraps");
    readCheck(base + 24'h001000, 8, "R11 stream");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule